// File: doc/BRIEF.md
# Sign-Magnitude Dual-Path Limb Adder-Subtractor

This block adds or subtracts two multi-limb integers held in sign-magnitude form. The magnitudes are read one limb per cycle, least significant limb first. The block drives the limb index, and the surrounding register bank answers in the same cycle with the two operand limbs at that index. Any index at or beyond an operand's length reads as zero, so the shorter operand is extended with zero limbs.

The block cannot know in advance which magnitude is larger, so it runs two carry chains side by side. The destination chain forms |A|+|B| when the signs call for a sum of magnitudes, and |A|-|B| when they call for a difference. The shadow chain always forms |B|-|A|. Each chain passes a one-bit carry from each limb to the next. Both limbs are written out together in each cycle. At the end, the final borrow and the operand signs pick the result that equals the true magnitude. The choice is reported as a swap flag, so the caller never has to convert a two's-complement result back to a magnitude.

Top module: `smag_addsub`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all 0.
- R2: A `start` accepted while idle is followed, from the next cycle, by one `wr_en` cycle for each limb index from 0 to N-1 in rising order, with no gaps. Here N is the larger of `len_a` and `len_b`. `wr_idx` gives the index being read and written. Operand limbs at an index equal to or above their own length are taken as zero.
- R3: Let the effective operation be a difference when `op_sub ^ sign_a ^ sign_b` is 1, and a sum otherwise. For an effective sum, `dst_limb` is a limb of |A|+|B|. For an effective difference, `dst_limb` is a limb of |A|-|B| modulo 2^(64N). `shd_limb` is always a limb of |B|-|A| modulo 2^(64N).
- R4: When an effective sum carries out of limb N-1, exactly one more write follows at index N, with `dst_limb` = 1 and `shd_limb` = 0. Otherwise there are exactly N writes.
- R5: For an effective sum, `swap` = 0 and the result sign is `sign_a`.
- R6: For an effective difference with |A| > |B|, `swap` = 0 and the result sign is `sign_a`.
- R7: For an effective difference with |B| > |A|, `swap` = 1 (the shadow result is the valid one). The result sign is `sign_b` for an add, and the inverse of `sign_b` for a subtract.
- R8: For an effective difference with |A| = |B|, `swap` = 0, `res_sign` = 0 and `res_size` = 1. In general, a zero result is always reported as positive.
- R9: `res_size` is one more than the index of the highest nonzero limb of the selected result, and is 1 when the result is zero.
- R10: `done` is high for exactly one cycle, the cycle after the last write, and `res_sign`, `res_size` and `swap` are valid in that cycle. `busy` is low in the following cycle.
- R11: A `start` pulse that arrives while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_sub | input | 1 | 1 = A minus B, 0 = A plus B |
| sign_a | input | 1 | Sign of A (1 = negative) |
| sign_b | input | 1 | Sign of B (1 = negative) |
| len_a | input | SW | Length of A in limbs, 1..ML |
| len_b | input | SW | Length of B in limbs, 1..ML |
| limb_a | input | LW | Limb of A at index `wr_idx` |
| limb_b | input | LW | Limb of B at index `wr_idx` |
| busy | output | 1 | Operation in progress |
| wr_en | output | 1 | Result limbs valid this cycle |
| wr_idx | output | SW | Limb index read and written this cycle |
| dst_limb | output | LW | Destination-slot limb (sum or A-B path) |
| shd_limb | output | LW | Shadow-slot limb (B-A path) |
| done | output | 1 | One-cycle completion pulse |
| res_sign | output | 1 | Result sign |
| res_size | output | SW | Result length in limbs, trailing zero limbs trimmed |
| swap | output | 1 | 1 = shadow slot holds the valid magnitude |

## Verification
The embedded properties check, on every cycle, several structural rules:
- the write index rises by one on each consecutive write, and writes happen only while busy;
- the carry limb appears only after an effective sum, at index N;
- a sum never reports a swap;
- the reported size never exceeds the limb count;
- `done` is a single-cycle pulse;
- a stray `start` does not break a run.

Only the directed scenarios can show the limb values themselves. They compare each limb against a wide reference model, and they confirm that the sign and the selected slot are correct for every sign and operation combination with |A| greater than, less than and equal to |B|. They also cover trimming of leading zero limbs and the extra carry limb.

// File: rtl/smag_addsub.sv
module smag_addsub #(
  parameter int LW = 64,
  parameter int ML = 8,
  localparam int SW = $clog2(ML + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_sub,
  input  logic          sign_a,
  input  logic          sign_b,
  input  logic [SW-1:0] len_a,
  input  logic [SW-1:0] len_b,
  input  logic [LW-1:0] limb_a,
  input  logic [LW-1:0] limb_b,
  output logic          busy,
  output logic          wr_en,
  output logic [SW-1:0] wr_idx,
  output logic [LW-1:0] dst_limb,
  output logic [LW-1:0] shd_limb,
  output logic          done,
  output logic          res_sign,
  output logic [SW-1:0] res_size,
  output logic          swap
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CARRY, S_FIN} st_t;

  st_t           st;
  logic          eff_sub, sub_r, sa_r, sb_r, cp, cq, nzf_p, nzf_q;
  logic [SW-1:0] n_r, la_r, lb_r, idx, nz_p, nz_q;

  wire [LW-1:0] a_z   = (idx < la_r) ? limb_a : '0;
  wire [LW-1:0] b_z   = (idx < lb_r) ? limb_b : '0;
  wire [LW-1:0] b_p   = eff_sub ? ~b_z : b_z;
  wire [LW:0]   sum_p = {1'b0, a_z} + {1'b0, b_p} + {{LW{1'b0}}, cp};
  wire [LW:0]   sum_q = {1'b0, b_z} + {1'b0, ~a_z} + {{LW{1'b0}}, cq};
  wire          run   = (st == S_RUN);
  wire          last  = (idx == n_r - SW'(1));
  wire          borrow = eff_sub & ~cp;
  wire          sel_nz = borrow ? nzf_q : nzf_p;

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign wr_en    = run | (st == S_CARRY);
  assign wr_idx   = idx;
  assign dst_limb = run ? sum_p[LW-1:0] : ((st == S_CARRY) ? {{(LW-1){1'b0}}, 1'b1} : '0);
  assign shd_limb = run ? sum_q[LW-1:0] : '0;
  assign swap     = borrow;
  assign res_size = (borrow ? nz_q : nz_p) + SW'(1);
  assign res_sign = sel_nz & (borrow ? (sb_r ^ sub_r) : sa_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      eff_sub <= 1'b0; sub_r <= 1'b0; sa_r <= 1'b0; sb_r <= 1'b0;
      cp <= 1'b0; cq <= 1'b0; nzf_p <= 1'b0; nzf_q <= 1'b0;
      n_r <= '0; la_r <= '0; lb_r <= '0; idx <= '0; nz_p <= '0; nz_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st      <= S_RUN;
          sub_r   <= op_sub;
          sa_r    <= sign_a;
          sb_r    <= sign_b;
          la_r    <= len_a;
          lb_r    <= len_b;
          n_r     <= (len_a > len_b) ? len_a : len_b;
          eff_sub <= op_sub ^ sign_a ^ sign_b;
          cp      <= op_sub ^ sign_a ^ sign_b;
          cq      <= 1'b1;
          idx     <= '0;
          nz_p    <= '0;
          nz_q    <= '0;
          nzf_p   <= 1'b0;
          nzf_q   <= 1'b0;
        end
        S_RUN: begin
          cp <= sum_p[LW];
          cq <= sum_q[LW];
          if (sum_p[LW-1:0] != '0) begin nz_p <= idx; nzf_p <= 1'b1; end
          if (sum_q[LW-1:0] != '0) begin nz_q <= idx; nzf_q <= 1'b1; end
          if (last) begin
            if (!eff_sub && sum_p[LW]) begin
              st  <= S_CARRY;
              idx <= idx + SW'(1);
            end else begin
              st <= S_FIN;
            end
          end else begin
            idx <= idx + SW'(1);
          end
        end
        S_CARRY: begin
          nz_p  <= idx;
          nzf_p <= 1'b1;
          st    <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + SW'(1)));

  a_r2_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  a_r4_carry_after_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CARRY) |-> (!eff_sub && wr_idx == n_r));

  a_r5_sum_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !eff_sub) |-> !swap);

  a_r9_size_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_size >= SW'(1) && res_size <= n_r + SW'(!eff_sub)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

endmodule

// File: tb/tb_smag_addsub.sv
`timescale 1ns/1ps
module tb_smag_addsub;
  localparam int LW = 64;
  localparam int ML = 8;
  localparam int SW = $clog2(ML + 2);
  localparam int W  = LW * (ML + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_sub = 1'b0, sign_a = 1'b0, sign_b = 1'b0;
  logic [SW-1:0] len_a = '0, len_b = '0;
  logic [LW-1:0] limb_a, limb_b;
  logic busy, wr_en, done, res_sign, swap;
  logic [SW-1:0] wr_idx, res_size;
  logic [LW-1:0] dst_limb, shd_limb;

  logic [LW-1:0] mem_a [ML];
  logic [LW-1:0] mem_b [ML];
  logic [LW-1:0] cap_d [ML+1];
  logic [LW-1:0] cap_s [ML+1];
  int nwr, total = 0, fails = 0;
  logic idx_ok, got_done, c_sign, c_swap;
  logic [SW-1:0] c_size;

  always #2 clk = ~clk;

  assign limb_a = (int'(wr_idx) < ML) ? mem_a[int'(wr_idx)] : '0;
  assign limb_b = (int'(wr_idx) < ML) ? mem_b[int'(wr_idx)] : '0;

  smag_addsub #(.LW(LW), .ML(ML)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub), .sign_a(sign_a), .sign_b(sign_b),
    .len_a(len_a), .len_b(len_b), .limb_a(limb_a), .limb_b(limb_b), .busy(busy), .wr_en(wr_en),
    .wr_idx(wr_idx), .dst_limb(dst_limb), .shd_limb(shd_limb), .done(done), .res_sign(res_sign),
    .res_size(res_size), .swap(swap));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] val(input bit is_b, input int len);
    logic [W-1:0] v = '0;
    for (int k = 0; k < ML; k++)
      if (k < len) v[k*LW +: LW] = is_b ? mem_b[k] : mem_a[k];
    return v;
  endfunction

  task automatic run_op(input bit op, input bit sa, input bit sb, input int la, input int lb,
                        input bit inject);
    int guard = 0;
    @(negedge clk);
    op_sub = op; sign_a = sa; sign_b = sb; len_a = SW'(la); len_b = SW'(lb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nwr = 0; idx_ok = 1'b1; got_done = 1'b0;
    while (!got_done && guard < 40) begin
      if (wr_en) begin
        if (int'(wr_idx) != nwr || nwr > ML) idx_ok = 1'b0;
        else begin cap_d[nwr] = dst_limb; cap_s[nwr] = shd_limb; end
        nwr++;
        if (inject && nwr == 2) begin
          start = 1'b1; op_sub = ~op; sign_a = ~sa; len_a = SW'(1); len_b = SW'(1);
        end else start = 1'b0;
      end
      if (done) begin
        got_done = 1'b1; c_sign = res_sign; c_swap = swap; c_size = res_size;
      end else begin
        @(negedge clk); guard++;
      end
    end
    start = 1'b0;
    chk(got_done, "R10", "done seen", 64'(got_done), 64'd1);
    @(negedge clk);
    chk(!done && !busy, "R10", "done single pulse", 64'(done | busy), 64'd0);
  endtask

  task automatic check_op(input bit op, input bit sa, input bit sb, input int la, input int lb,
                          input bit inject);
    logic [W-1:0] va, vb, p, q, mask, sel;
    int n, nexp, esz, bad;
    bit effs, bor, esign;
    string tg;
    run_op(op, sa, sb, la, lb, inject);
    va = val(1'b0, la); vb = val(1'b1, lb);
    n = (la > lb) ? la : lb;
    mask = {W{1'b1}} >> (LW * (ML + 1 - n));
    effs = op ^ sa ^ sb;
    p = effs ? ((va - vb) & mask) : (va + vb);
    q = (vb - va) & mask;
    nexp = n + ((!effs && ((p >> (LW * n)) != '0)) ? 1 : 0);
    bor = effs && (vb > va);
    sel = bor ? q : p;
    esz = 1;
    for (int k = 0; k <= ML; k++) if (sel[k*LW +: LW] != '0) esz = k + 1;
    esign = (sel != '0) && (bor ? (sb ^ op) : sa);
    tg = !effs ? "R5" : (bor ? "R7" : ((va == vb) ? "R8" : "R6"));
    chk(idx_ok, "R2", "write index order", 64'(nwr), 64'(nexp));
    chk(nwr == nexp, "R4", "write count", 64'(nwr), 64'(nexp));
    bad = -1;
    for (int k = 0; k < nexp && k <= ML; k++) begin
      if (cap_d[k] != p[k*LW +: LW]) bad = k;
      if (cap_s[k] != ((k < n) ? q[k*LW +: LW] : '0)) bad = k;
    end
    chk(bad < 0, "R3", "limb values", 64'(bad), 64'hffff_ffff_ffff_ffff);
    chk(c_swap == bor, tg, "swap", 64'(c_swap), 64'(bor));
    chk(c_sign == esign, tg, "sign", 64'(c_sign), 64'(esign));
    chk(int'(c_size) == esz, "R9", "size", 64'(c_size), 64'(esz));
  endtask

  task automatic fill(input int kind, output int la, output int lb);
    logic [W-1:0] va, vb;
    logic [LW-1:0] t;
    int ti;
    la = 1 + ($urandom % ML); lb = 1 + ($urandom % ML);
    for (int k = 0; k < ML; k++) begin
      mem_a[k] = (k < la) ? {$urandom, $urandom} : '0;
      mem_b[k] = (k < lb) ? {$urandom, $urandom} : '0;
    end
    if (la == lb && la > 1 && ($urandom % 2) == 1) mem_b[la-1] = mem_a[la-1];
    if (kind == 2) begin
      for (int k = 0; k < ML; k++) mem_b[k] = mem_a[k];
      if (lb < la) lb = la;
    end else begin
      va = val(1'b0, la); vb = val(1'b1, lb);
      if (va == vb) begin mem_a[0] = mem_a[0] ^ 64'h1; va = val(1'b0, la); end
      if ((kind == 0) != (va > vb)) begin
        for (int k = 0; k < ML; k++) begin t = mem_a[k]; mem_a[k] = mem_b[k]; mem_b[k] = t; end
        ti = la; la = lb; lb = ti;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en, "R1", "reset outputs", 64'({busy, done, wr_en}), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep();
    int la, lb;
    for (int kind = 0; kind < 3; kind++)
      for (int combo = 0; combo < 8; combo++)
        for (int rep = 0; rep < 3; rep++) begin
          fill(kind, la, lb);
          check_op(combo[2], combo[1], combo[0], la, lb, 1'b0);
        end
  endtask

  task automatic t_carry();
    for (int k = 0; k < ML; k++) begin mem_a[k] = '1; mem_b[k] = (k < 2) ? '1 : '0; end
    check_op(1'b0, 1'b1, 1'b1, ML, 2, 1'b0);
    check_op(1'b1, 1'b0, 1'b1, 3, 2, 1'b0);
  endtask

  task automatic t_zero();
    for (int k = 0; k < ML; k++) begin mem_a[k] = '0; mem_b[k] = '0; end
    check_op(1'b0, 1'b1, 1'b1, 4, 2, 1'b0);
    check_op(1'b1, 1'b1, 1'b1, 3, 5, 1'b0);
  endtask

  task automatic t_busy_start();
    int la, lb;
    fill(1, la, lb);
    if (la < 3 && lb < 3) begin la = 3; mem_a[1] = 64'h5; mem_a[2] = 64'h7; end
    check_op(1'b1, 1'b0, 1'b0, la, lb, 1'b1);
  endtask

  initial begin
    #(4.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < ML; k++) begin mem_a[k] = '0; mem_b[k] = '0; end
    t_reset();
    t_sweep();
    t_carry();
    t_zero();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end
endmodule